// File: doc/BRIEF.md
# Traffic Phase Sequencer

This block steers a population of traffic-generating nodes through a repeating series of run phases and then closes the run with a verdict. In the normal phase every node both sends and absorbs traffic. In the jam phase nodes only send, filling the network until no node can place another packet. In the drain phase nodes only absorb, until the network holds no undelivered packet. A programmed number of such rounds is followed by a terminal phase that reports whether the run passed.

Phase exits in the jam and drain phases depend only on the node status. Each node reports whether it can still inject, how many of its packets are still in flight, and a one-cycle pulse whenever it makes forward progress. These are reduced across all nodes and registered once before the sequencer acts on them. A watchdog counts cycles without any progress pulse; if it reaches a programmable limit, the run is declared hung and ends immediately as a failure.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: After reset, phaseCode is 0 (idle), all injectEn and receiveEn bits are 0, and runDone, runPass and runHung are 0.
- R2: A startRun pulse seen in idle (code 0) or end (code 4) moves the block to normal (code 1) on that edge and clears runHung, runPass and runDone. Normal holds all injectEn and receiveEn bits at 1 and lasts normalLen+1 cycles, then moves to jam (code 2).
- R3: In jam, every injectEn bit is 1 and every receiveEn bit is 0. Jam persists while any nodeCanInject bit is 1. Once all nodeCanInject bits are 0, the block enters drain (code 3) on the second rising edge, because the aggregate is registered for one cycle.
- R4: In drain, every injectEn bit is 0 and every receiveEn bit is 1. Drain persists while any node's outstanding count (an OUT_W-bit field at bit offset i*OUT_W for node i) is non-zero. It exits on the second rising edge after all counts reach zero.
- R5: A drain exit returns to normal while rounds remain and goes to end otherwise. The number of normal phases in a run equals roundCount, and a roundCount of 0 runs one round.
- R6: The watchdog restarts on any nodeProgress pulse. If the running phases (codes 1 to 3) see no pulse, the block spends exactly timeoutLimit+1 cycles in them after the start edge, then enters end with runHung=1 and runPass=0.
- R7: End (code 4) holds all enables at 0 and runDone at 1 until the next startRun. runPass is 1 exactly when the run did not hang and every nodeChecksOk bit was 1 in the cycle before end was entered.
- R8: A startRun pulse during normal, jam or drain has no effect on the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startRun | input | 1 | Begins a run from idle or end |
| roundCount | input | RND_W | Number of normal/jam/drain rounds (0 treated as 1) |
| normalLen | input | DW_W | Normal phase length minus one, in cycles |
| timeoutLimit | input | TO_W | Watchdog limit in cycles without progress |
| nodeCanInject | input | NODES | Per-node ability to inject another packet |
| nodeOutstanding | input | NODES*OUT_W | Per-node count of packets in flight |
| nodeProgress | input | NODES | Per-node forward-progress pulse |
| nodeChecksOk | input | NODES | Per-node self-consistency result |
| phaseCode | output | 3 | 0 idle, 1 normal, 2 jam, 3 drain, 4 end |
| injectEn | output | NODES | Per-node injection permission |
| receiveEn | output | NODES | Per-node reception permission |
| runDone | output | 1 | Run has reached end |
| runPass | output | 1 | Run ended without hang and with all checks good |
| runHung | output | 1 | Run was ended by the watchdog |

## Verification
A corrupted phase register appears at once on phaseCode and on the enable vectors, so every check of the enables in a phase also checks the state. A wrong aggregate latency shifts the jam and drain exits by a cycle, and the bench catches this by sampling exactly one and two edges after the last node changes. A faulty round or dwell counter shows up as a wrong count of normal phases or of normal-phase cycles within a single run. A watchdog that fails to reload or to expire shows up as a false or missing hang, visible at the exact cycle count after start.

// File: rtl/phase_ctrl_pkg.sv
package phase_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_NORMAL = 3'd1,
    PH_JAM    = 3'd2,
    PH_DRAIN  = 3'd3,
    PH_END    = 3'd4
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadRun;
    logic loadDwell;
    logic dwellRun;
    logic decRound;
    logic wdogEnable;
    logic enterEnd;
  } ctrl_strobe_t;

  // conditions from the datapath to the sequencer
  typedef struct packed {
    logic dwellDone;
    logic lastRound;
    logic noneCanInj;
    logic allEmpty;
    logic wdExpired;
  } dp_status_t;

endpackage

// File: rtl/phase_datapath.sv
module phase_datapath
  import phase_ctrl_pkg::*;
#(
  parameter int NODES = 4,
  parameter int OUT_W = 8,
  parameter int RND_W = 4,
  parameter int DW_W  = 8,
  parameter int TO_W  = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strobe,
  input  logic [NODES-1:0]       nodeCanInject,
  input  logic [NODES*OUT_W-1:0] nodeOutstanding,
  input  logic [NODES-1:0]       nodeProgress,
  input  logic [NODES-1:0]       nodeChecksOk,
  input  logic [RND_W-1:0]       roundCount,
  input  logic [DW_W-1:0]        normalLen,
  input  logic [TO_W-1:0]        timeoutLimit,
  output dp_status_t             status,
  output logic                   runHung,
  output logic                   runPass
);

  localparam logic [RND_W-1:0] ONE_ROUND = RND_W'(1);
  localparam logic [TO_W-1:0]  WD_MAX    = {TO_W{1'b1}};

  logic [NODES-1:0] nodeEmpty;

  generate
    for (genvar i = 0; i < NODES; i++) begin : g_empty
      assign nodeEmpty[i] = (nodeOutstanding[i*OUT_W +: OUT_W] == '0);
    end
  endgenerate

  // one-cycle registered aggregates
  logic aggNoneCanInj, aggAllEmpty, aggProgress, aggChecksOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aggNoneCanInj <= 1'b0;
      aggAllEmpty   <= 1'b0;
      aggProgress   <= 1'b0;
      aggChecksOk   <= 1'b0;
    end else begin
      aggNoneCanInj <= ~|nodeCanInject;
      aggAllEmpty   <= &nodeEmpty;
      aggProgress   <= |nodeProgress;
      aggChecksOk   <= &nodeChecksOk;
    end
  end

  // normal-phase dwell counter
  logic [DW_W-1:0] dwellCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (strobe.loadDwell) begin
      dwellCnt <= normalLen;
    end else if (strobe.dwellRun && dwellCnt != '0) begin
      dwellCnt <= dwellCnt - 1'b1;
    end
  end

  // rounds remaining
  logic [RND_W-1:0] roundsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      roundsLeft <= '0;
    end else if (strobe.loadRun) begin
      roundsLeft <= (roundCount == '0) ? ONE_ROUND : roundCount;
    end else if (strobe.decRound && roundsLeft != '0) begin
      roundsLeft <= roundsLeft - 1'b1;
    end
  end

  // no-progress watchdog
  logic [TO_W-1:0] wdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (!strobe.wdogEnable || aggProgress) begin
      wdCnt <= '0;
    end else if (wdCnt != WD_MAX) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  // verdict
  logic hungQ, passQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hungQ <= 1'b0;
      passQ <= 1'b0;
    end else if (strobe.loadRun) begin
      hungQ <= 1'b0;
      passQ <= 1'b0;
    end else if (strobe.enterEnd) begin
      hungQ <= status.wdExpired;
      passQ <= !status.wdExpired && aggChecksOk;
    end
  end

  always_comb begin
    status.dwellDone  = (dwellCnt == '0);
    status.lastRound  = (roundsLeft <= ONE_ROUND);
    status.noneCanInj = aggNoneCanInj;
    status.allEmpty   = aggAllEmpty;
    status.wdExpired  = strobe.wdogEnable && (wdCnt >= timeoutLimit);
  end

  assign runHung = hungQ;
  assign runPass = passQ;

  AST_WD_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    aggProgress |=> (wdCnt == '0)); // R6

  AST_ROUNDS_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wdogEnable && !strobe.loadRun) |-> (roundsLeft != '0)); // R5

  AST_PASS_EXCLUDES_HANG: assert property (@(posedge clk) disable iff (!rstN)
    !(hungQ && passQ)); // R7

endmodule

// File: rtl/phase_control.sv
module phase_control
  import phase_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startRun,
  input  dp_status_t   status,
  output phase_e       phaseQ,
  output ctrl_strobe_t strobe
);

  phase_e phaseD;
  logic   running;

  assign running = (phaseQ == PH_NORMAL) || (phaseQ == PH_JAM) || (phaseQ == PH_DRAIN);

  always_comb begin
    phaseD            = phaseQ;
    strobe            = '0;
    strobe.wdogEnable = running;
    unique case (phaseQ)
      PH_IDLE, PH_END: begin
        if (startRun) begin
          phaseD           = PH_NORMAL;
          strobe.loadRun   = 1'b1;
          strobe.loadDwell = 1'b1;
        end
      end
      PH_NORMAL: begin
        strobe.dwellRun = 1'b1;
        if (status.wdExpired) begin
          phaseD          = PH_END;
          strobe.enterEnd = 1'b1;
        end else if (status.dwellDone) begin
          phaseD = PH_JAM;
        end
      end
      PH_JAM: begin
        if (status.wdExpired) begin
          phaseD          = PH_END;
          strobe.enterEnd = 1'b1;
        end else if (status.noneCanInj) begin
          phaseD = PH_DRAIN;
        end
      end
      PH_DRAIN: begin
        if (status.wdExpired) begin
          phaseD          = PH_END;
          strobe.enterEnd = 1'b1;
        end else if (status.allEmpty) begin
          if (status.lastRound) begin
            phaseD          = PH_END;
            strobe.enterEnd = 1'b1;
          end else begin
            phaseD           = PH_NORMAL;
            strobe.decRound  = 1'b1;
            strobe.loadDwell = 1'b1;
          end
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  AST_JAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_JAM && !status.noneCanInj && !status.wdExpired) |=> (phaseQ == PH_JAM)); // R3

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_DRAIN && !status.allEmpty && !status.wdExpired) |=> (phaseQ == PH_DRAIN)); // R4

  AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_DRAIN && status.allEmpty && !status.wdExpired)
      |=> (phaseQ == PH_NORMAL || phaseQ == PH_END)); // R5

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_END && !startRun) |=> (phaseQ == PH_END)); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (running && startRun) |=> (phaseQ != PH_IDLE)); // R8

endmodule

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl
  import phase_ctrl_pkg::*;
#(
  parameter int NODES = 4,
  parameter int OUT_W = 8,
  parameter int RND_W = 4,
  parameter int DW_W  = 8,
  parameter int TO_W  = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startRun,
  input  logic [RND_W-1:0]       roundCount,
  input  logic [DW_W-1:0]        normalLen,
  input  logic [TO_W-1:0]        timeoutLimit,
  input  logic [NODES-1:0]       nodeCanInject,
  input  logic [NODES*OUT_W-1:0] nodeOutstanding,
  input  logic [NODES-1:0]       nodeProgress,
  input  logic [NODES-1:0]       nodeChecksOk,
  output logic [2:0]             phaseCode,
  output logic [NODES-1:0]       injectEn,
  output logic [NODES-1:0]       receiveEn,
  output logic                   runDone,
  output logic                   runPass,
  output logic                   runHung
);

  phase_e       phaseQ;
  ctrl_strobe_t strobe;
  dp_status_t   status;

  phase_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .startRun (startRun),
    .status   (status),
    .phaseQ   (phaseQ),
    .strobe   (strobe)
  );

  phase_datapath #(
    .NODES (NODES),
    .OUT_W (OUT_W),
    .RND_W (RND_W),
    .DW_W  (DW_W),
    .TO_W  (TO_W)
  ) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .nodeCanInject   (nodeCanInject),
    .nodeOutstanding (nodeOutstanding),
    .nodeProgress    (nodeProgress),
    .nodeChecksOk    (nodeChecksOk),
    .roundCount      (roundCount),
    .normalLen       (normalLen),
    .timeoutLimit    (timeoutLimit),
    .status          (status),
    .runHung         (runHung),
    .runPass         (runPass)
  );

  logic injAll, rcvAll;
  assign injAll = (phaseQ == PH_NORMAL) || (phaseQ == PH_JAM);
  assign rcvAll = (phaseQ == PH_NORMAL) || (phaseQ == PH_DRAIN);

  generate
    for (genvar i = 0; i < NODES; i++) begin : g_enable
      assign injectEn[i]  = injAll;
      assign receiveEn[i] = rcvAll;
    end
  endgenerate

  assign phaseCode = phaseQ;
  assign runDone   = (phaseQ == PH_END);

  AST_HANG_FORCES_END: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wdogEnable && status.wdExpired) |=> (phaseQ == PH_END && runHung && !runPass)); // R6

  AST_NO_INJECT_WHILE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> (injectEn == '0)); // R7

endmodule

// File: tb/traffic_phase_ctrl_test.sv
`timescale 1ns/1ps
module traffic_phase_ctrl_test;

  localparam int NODES = 4;
  localparam int OUT_W = 8;
  localparam int RND_W = 4;
  localparam int DW_W  = 8;
  localparam int TO_W  = 10;
  localparam logic [NODES-1:0] ALL = {NODES{1'b1}};

  logic                   clk = 1'b0;
  logic                   rstN;
  logic                   startRun;
  logic [RND_W-1:0]       roundCount;
  logic [DW_W-1:0]        normalLen;
  logic [TO_W-1:0]        timeoutLimit;
  logic [NODES-1:0]       nodeCanInject;
  logic [NODES*OUT_W-1:0] nodeOutstanding;
  logic [NODES-1:0]       nodeProgress;
  logic [NODES-1:0]       nodeChecksOk;
  logic [2:0]             phaseCode;
  logic [NODES-1:0]       injectEn;
  logic [NODES-1:0]       receiveEn;
  logic                   runDone, runPass, runHung;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  traffic_phase_ctrl #(
    .NODES(NODES), .OUT_W(OUT_W), .RND_W(RND_W), .DW_W(DW_W), .TO_W(TO_W)
  ) uut (
    .clk(clk), .rstN(rstN), .startRun(startRun), .roundCount(roundCount),
    .normalLen(normalLen), .timeoutLimit(timeoutLimit),
    .nodeCanInject(nodeCanInject), .nodeOutstanding(nodeOutstanding),
    .nodeProgress(nodeProgress), .nodeChecksOk(nodeChecksOk),
    .phaseCode(phaseCode), .injectEn(injectEn), .receiveEn(receiveEn),
    .runDone(runDone), .runPass(runPass), .runHung(runHung)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    startRun = 1'b1;
    tick(1);
    startRun = 1'b0;
  endtask

  function automatic logic [NODES*OUT_W-1:0] fill_out(input int v);
    logic [NODES*OUT_W-1:0] r;
    for (int i = 0; i < NODES; i++) r[i*OUT_W +: OUT_W] = OUT_W'(v);
    return r;
  endfunction

  task automatic test_reset();
    chk("R1 phase", phaseCode, 0);
    chk("R1 inject", injectEn, 0);
    chk("R1 receive", receiveEn, 0);
    chk("R1 done", runDone, 0);
    chk("R1 pass", runPass, 0);
    chk("R1 hung", runHung, 0);
  endtask

  task automatic test_single_round();
    int n;
    roundCount = 4'd1; normalLen = 8'd3; timeoutLimit = 10'd1000;
    nodeCanInject = ALL; nodeOutstanding = fill_out(4);
    pulse_start();
    chk("R2 enter normal", phaseCode, 1);
    chk("R2 inject normal", injectEn, ALL);
    chk("R2 receive normal", receiveEn, ALL);
    n = 0;
    while (phaseCode == 3'd1 && n < 100) begin n++; tick(1); end
    chk("R2 normal length", n, 4);
    chk("R3 jam phase", phaseCode, 2);
    chk("R3 inject jam", injectEn, ALL);
    chk("R3 receive jam", receiveEn, 0);
    pulse_start();
    chk("R8 start ignored in jam", phaseCode, 2);
    nodeCanInject = 4'b0100;
    tick(3);
    chk("R3 hold while one can inject", phaseCode, 2);
    nodeCanInject = '0;
    tick(1);
    chk("R3 still jam after one edge", phaseCode, 2);
    tick(1);
    chk("R3 drain after two edges", phaseCode, 3);
    chk("R4 inject drain", injectEn, 0);
    chk("R4 receive drain", receiveEn, ALL);
    pulse_start();
    chk("R8 start ignored in drain", phaseCode, 3);
    nodeOutstanding = '0;
    nodeOutstanding[3*OUT_W +: OUT_W] = 8'd1;
    tick(3);
    chk("R4 hold while node3 outstanding", phaseCode, 3);
    nodeOutstanding = '0;
    tick(1);
    chk("R4 still drain after one edge", phaseCode, 3);
    tick(1);
    chk("R5 single round ends", phaseCode, 4);
    chk("R7 done", runDone, 1);
    chk("R7 pass", runPass, 1);
    chk("R7 not hung", runHung, 0);
    chk("R7 inject off", injectEn, 0);
    chk("R7 receive off", receiveEn, 0);
    tick(3);
    chk("R7 end sticky", phaseCode, 4);
  endtask

  task automatic run_auto(input int rnds, output int normals);
    logic [2:0] prev;
    roundCount = RND_W'(rnds); normalLen = 8'd1; timeoutLimit = 10'd1000;
    nodeCanInject = ALL; nodeOutstanding = fill_out(5);
    prev = phaseCode;
    normals = 0;
    pulse_start();
    for (int c = 0; c < 500; c++) begin
      if (phaseCode == 3'd4) break;
      if (phaseCode == 3'd1 && prev != 3'd1) normals++;
      prev = phaseCode;
      if (phaseCode == 3'd1) begin nodeCanInject = ALL; nodeOutstanding = fill_out(5); end
      else if (phaseCode == 3'd2) nodeCanInject = '0;
      else if (phaseCode == 3'd3) nodeOutstanding = '0;
      tick(1);
    end
  endtask

  task automatic test_multi_round();
    int nrm;
    run_auto(3, nrm);
    chk("R5 three rounds", nrm, 3);
    chk("R5 ended", phaseCode, 4);
    chk("R7 pass multi", runPass, 1);
    run_auto(0, nrm);
    chk("R5 zero rounds as one", nrm, 1);
    chk("R5 ended zero", phaseCode, 4);
  endtask

  task automatic test_checks_fail();
    int nrm;
    nodeChecksOk = 4'b1110;
    run_auto(1, nrm);
    chk("R7 done with bad check", runDone, 1);
    chk("R7 fail on bad check", runPass, 0);
    chk("R7 no hang on bad check", runHung, 0);
    nodeChecksOk = ALL;
  endtask

  task automatic test_hang();
    int n;
    roundCount = 4'd1; normalLen = 8'd50; timeoutLimit = 10'd5;
    nodeCanInject = ALL; nodeOutstanding = fill_out(2); nodeProgress = '0;
    pulse_start();
    n = 0;
    while (phaseCode >= 3'd1 && phaseCode <= 3'd3 && n < 200) begin n++; tick(1); end
    chk("R6 cycles before hang", n, 6);
    chk("R6 end on hang", phaseCode, 4);
    chk("R6 hung flag", runHung, 1);
    chk("R6 pass low on hang", runPass, 0);
  endtask

  task automatic test_progress_alive();
    int c;
    roundCount = 4'd1; normalLen = 8'd20; timeoutLimit = 10'd5;
    nodeCanInject = ALL; nodeOutstanding = fill_out(2);
    pulse_start();
    chk("R2 hung cleared on restart", runHung, 0);
    c = 0;
    while (phaseCode != 3'd4 && c < 300) begin
      nodeProgress = (c % 3 == 0) ? 4'b0010 : 4'b0000;
      if (phaseCode == 3'd2) nodeCanInject = '0;
      if (phaseCode == 3'd3) nodeOutstanding = '0;
      c++;
      tick(1);
      if (c == 10) chk("R6 alive in normal", phaseCode, 1);
    end
    nodeProgress = '0;
    chk("R6 progress avoids hang", runHung, 0);
    chk("R6 pass with progress", runPass, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startRun = 1'b0; roundCount = '0; normalLen = '0;
    timeoutLimit = '0; nodeCanInject = '0; nodeOutstanding = '0;
    nodeProgress = '0; nodeChecksOk = ALL;
    tick(3);
    rstN = 1'b1;
    tick(1);
    test_reset();
    test_single_round();
    test_multi_round();
    test_checks_fail();
    test_hang();
    test_progress_alive();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule